// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic unit of an accumulator machine with 8-bit data. Each cycle it takes two operands and a 3-bit operation code. The operations are add, add with carry, subtract, increment, decrement, AND, OR and XOR. The 8-bit result is presented combinationally.

From the same operation the block derives five status flags: sign, zero, auxiliary (nibble) carry, parity and carry. A flag register captures them on the rising clock edge, but only when the update enable is high. The add-with-carry operation takes its carry input from the stored carry flag, so a wide add is a chain of ADC operations with the update enable held high.

Increment and decrement are meant for counter-style register updates. They refresh every flag except carry, which keeps its stored value.

Top module: `acc_alu_flags`

## Requirements
- R1: `result_o` is computed combinationally and wraps modulo 256. The operation codes are:
  - 0 ADD: a+b
  - 1 ADC: a+b+C, where C is the stored carry flag
  - 2 SUB: a-b
  - 3 INC: a+1
  - 4 DEC: a-1
  - 5 AND: a&b
  - 6 OR: a|b
  - 7 XOR: a^b
- R2: After an update, `sign_o` equals bit 7 of the result of the updating operation.
- R3: After an update, `zero_o` is 1 exactly when the 8-bit result was 0x00.
- R4: After an update, `parity_o` is 1 when the result held an even number of ones and 0 when it held an odd number.
- R5: For ADD and ADC, `carry_o` becomes the carry out of bit 7 of the full sum, including the carry input.
- R6: For SUB, `carry_o` becomes 1 exactly when operand a is less than operand b as unsigned numbers (a borrow).
- R7: `aux_carry_o` is set as follows:
  - ADD, ADC and INC: the carry from bit 3 into bit 4.
  - SUB: 1 when the low nibble of a is less than the low nibble of b.
  - DEC: 1 when the low nibble of a is 0.
- R8: INC and DEC leave `carry_o` at its previous value while updating the other four flags.
- R9: AND, OR and XOR clear `carry_o`. AND sets `aux_carry_o`; OR and XOR clear it.
- R10: When `flag_we_i` is low at a clock edge, all five flags keep their values, and ADC still uses the held carry.
- R11: While `rst_ni` is low, all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 8 | Operand a (accumulator side) |
| op_b_i | input | 8 | Operand b |
| op_sel_i | input | 3 | Operation code, per R1 |
| flag_we_i | input | 1 | Flag register update enable |
| result_o | output | 8 | Combinational result |
| sign_o | output | 1 | Stored sign flag |
| zero_o | output | 1 | Stored zero flag |
| aux_carry_o | output | 1 | Stored nibble carry/borrow flag |
| parity_o | output | 1 | Stored even-parity flag |
| carry_o | output | 1 | Stored carry/borrow flag |

## Verification
The flags are the only state in the block, so any wrong internal value is visible at the flag outputs one edge after the update that caused it. A carry flag that is wrongly kept or lost also shows up combinationally on `result_o` at the very next ADC, off by one. Increment and decrement steps at the nibble and byte boundaries, and enable-low cycles, catch a carry that is wrongly overwritten within one cycle.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic aux;
    logic parity;
    logic carry;
  } flags_t;

  function automatic logic op_is_logic(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_step(alu_op_e op);
    return (op == OP_INC) || (op == OP_DEC);
  endfunction

endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
module alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              aux_o
);
  localparam int HI_W = DATA_W - NIB_W;

  logic [DATA_W-1:0] addend;
  logic              cin;
  logic              inv;   // subtract family: carries become borrows
  logic [NIB_W:0]    lo_sum;
  logic [HI_W:0]     hi_sum;

  always_comb begin
    addend = b_i;
    cin    = 1'b0;
    inv    = 1'b0;
    unique case (op_i)
      OP_ADD: ;
      OP_ADC: cin = carry_i;
      OP_SUB: begin addend = ~b_i; cin = 1'b1; inv = 1'b1; end
      OP_INC: begin addend = '0;   cin = 1'b1; end
      OP_DEC: begin addend = '1;   inv = 1'b1; end
      default: ;
    endcase
  end

  // Two slices so the nibble carry is a real node, not a recomputation
  always_comb begin
    lo_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, addend[NIB_W-1:0]}
           + {{NIB_W{1'b0}}, cin};
    hi_sum = {1'b0, a_i[DATA_W-1:NIB_W]} + {1'b0, addend[DATA_W-1:NIB_W]}
           + {{HI_W{1'b0}}, lo_sum[NIB_W]};
  end

  assign sum_o   = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
  assign carry_o = hi_sum[HI_W] ^ inv;
  assign aux_o   = lo_sum[NIB_W] ^ inv;

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              aux_o
);
  always_comb begin
    res_o = '0;
    aux_o = 1'b0;
    unique case (op_i)
      OP_AND: begin res_o = a_i & b_i; aux_o = 1'b1; end
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg
  import acc_alu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_i,
  input  alu_op_e op_i,
  input  flags_t  next_i,
  output flags_t  flags_o
);
  flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (we_i) begin
      flags_q <= next_i;
      if (op_is_step(op_i)) flags_q.carry <= flags_q.carry;
    end
  end

  assign flags_o = flags_q;

  // R10
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flags_q));

  // R8
  step_keeps_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_is_step(op_i)) |=> (flags_q.carry == $past(flags_q.carry)));

endmodule

// File: rtl/acc_alu_flags.sv
`timescale 1ns/1ps
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [2:0]        op_sel_i,
  input  logic              flag_we_i,
  output logic [DATA_W-1:0] result_o,
  output logic              sign_o,
  output logic              zero_o,
  output logic              aux_carry_o,
  output logic              parity_o,
  output logic              carry_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] arith_res, logic_res, res;
  logic              arith_cy, arith_ac, logic_ac;
  flags_t            flags_d, flags_q;

  assign op = alu_op_e'(op_sel_i);

  alu_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .op_i    (op),
    .carry_i (flags_q.carry),
    .sum_o   (arith_res),
    .carry_o (arith_cy),
    .aux_o   (arith_ac)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .op_i  (op),
    .res_o (logic_res),
    .aux_o (logic_ac)
  );

  always_comb begin
    res            = op_is_logic(op) ? logic_res : arith_res;
    flags_d.sign   = res[DATA_W-1];
    flags_d.zero   = (res == '0);
    flags_d.parity = ~^res;
    flags_d.carry  = op_is_logic(op) ? 1'b0 : arith_cy;
    flags_d.aux    = op_is_logic(op) ? logic_ac : arith_ac;
  end

  alu_flag_reg u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (flag_we_i),
    .op_i    (op),
    .next_i  (flags_d),
    .flags_o (flags_q)
  );

  assign result_o    = res;
  assign sign_o      = flags_q.sign;
  assign zero_o      = flags_q.zero;
  assign aux_carry_o = flags_q.aux;
  assign parity_o    = flags_q.parity;
  assign carry_o     = flags_q.carry;

  // R2
  sign_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (sign_o == $past(result_o[DATA_W-1])));

  // R3
  zero_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (zero_o == ($past(result_o) == '0)));

  // R4
  parity_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (parity_o == ($countones($past(result_o)) % 2 == 0)));

  // R6
  sub_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_sel_i == 3'd2) |=> (carry_o == ($past(op_a_i) < $past(op_b_i))));

  // R9
  logic_clears_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_sel_i >= 3'd5) |=> !carry_o);

endmodule

// File: tb/acc_alu_flags_bench.sv
`timescale 1ns/1ps
module acc_alu_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [2:0] sel = '0;
  logic       we = 1'b0;
  logic [7:0] res;
  logic       s_o, z_o, ac_o, p_o, c_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side flag model
  logic m_s, m_z, m_ac, m_p, m_c;

  always #2 clk = ~clk;

  acc_alu_flags u_acc_alu_flags (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b), .op_sel_i(sel),
    .flag_we_i(we), .result_o(res), .sign_o(s_o), .zero_o(z_o),
    .aux_carry_o(ac_o), .parity_o(p_o), .carry_o(c_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string cy_tag, input string ac_tag);
    chk("R2 sign", s_o, m_s);
    chk("R3 zero", z_o, m_z);
    chk("R4 parity", p_o, m_p);
    chk(ac_tag, ac_o, m_ac);
    chk(cy_tag, c_o, m_c);
  endtask

  // op codes: 0 add 1 adc 2 sub 3 inc 4 dec 5 and 6 or 7 xor
  task automatic run_op(input int op, input int av, input int bv, input logic wen);
    int    r, ec, eac, cin;
    string cy_tag, ac_tag;
    cin = m_c;
    ec  = m_c;
    eac = 0;
    case (op)
      0, 1: begin
        if (op == 0) cin = 0;
        r   = av + bv + cin;
        ec  = (r > 255);
        eac = ((av % 16) + (bv % 16) + cin) > 15;
        cy_tag = "R5 carry"; ac_tag = "R7 aux";
      end
      2: begin
        r = av - bv; ec = (av < bv); eac = (av % 16) < (bv % 16);
        cy_tag = "R6 borrow"; ac_tag = "R7 aux";
      end
      3: begin r = av + 1; eac = (av % 16) == 15; cy_tag = "R8 carry"; ac_tag = "R7 aux"; end
      4: begin r = av - 1; eac = (av % 16) == 0;  cy_tag = "R8 carry"; ac_tag = "R7 aux"; end
      5: begin r = av & bv; ec = 0; eac = 1; cy_tag = "R9 carry"; ac_tag = "R9 aux"; end
      6: begin r = av | bv; ec = 0; eac = 0; cy_tag = "R9 carry"; ac_tag = "R9 aux"; end
      default: begin r = av ^ bv; ec = 0; eac = 0; cy_tag = "R9 carry"; ac_tag = "R9 aux"; end
    endcase
    r = r & 255;
    @(negedge clk);
    a = 8'(av); b = 8'(bv); sel = 3'(op); we = wen;
    #1;
    chk("R1 result", res, r);
    @(posedge clk);
    #1;
    if (wen) begin
      m_s = r[7]; m_z = (r == 0); m_p = ($countones(8'(r)) % 2 == 0);
      m_ac = eac[0]; m_c = ec[0];
    end else begin
      cy_tag = "R10 hold carry"; ac_tag = "R10 hold aux";
    end
    chk_flags(cy_tag, ac_tag);
  endtask

  task automatic t_reset;
    #1;
    m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_c = 0;
    chk_flags("R11 reset carry", "R11 reset aux");
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_add;
    run_op(0, 8'h12, 8'h34, 1);
    run_op(0, 8'h0F, 8'h01, 1);  // nibble carry
    run_op(0, 8'h80, 8'h80, 1);  // zero and carry
    run_op(0, 8'h7F, 8'h00, 1);  // odd parity
    run_op(0, 8'hFF, 8'hFF, 1);
  endtask

  task automatic t_adc;
    run_op(0, 8'hF0, 8'h20, 1);  // sets C
    run_op(1, 8'h0E, 8'h01, 1);  // 0E+01+1 nibble carry
    run_op(0, 8'hFF, 8'h01, 1);  // C=1
    run_op(1, 8'hFF, 8'h00, 1);  // FF+0+1 = 00 carry
  endtask

  task automatic t_sub;
    run_op(2, 8'h50, 8'h20, 1);
    run_op(2, 8'h20, 8'h50, 1);  // borrow
    run_op(2, 8'h33, 8'h33, 1);  // zero, no borrow
    run_op(2, 8'h10, 8'h01, 1);  // nibble borrow
  endtask

  task automatic t_step;
    run_op(0, 8'hFF, 8'h01, 1);  // C=1
    run_op(3, 8'hFF, 8'h00, 1);  // wraps, C kept 1
    run_op(3, 8'h0F, 8'h00, 1);
    run_op(2, 8'h05, 8'h01, 1);  // C=0
    run_op(4, 8'h00, 8'h00, 1);  // wraps to FF, C kept 0
    run_op(4, 8'h11, 8'h00, 1);
    run_op(4, 8'h01, 8'h00, 1);  // zero via dec
  endtask

  task automatic t_logic;
    run_op(0, 8'hFF, 8'h01, 1);  // C=1
    run_op(5, 8'hF0, 8'h3C, 1);
    run_op(0, 8'hFF, 8'h01, 1);
    run_op(6, 8'h0F, 8'h00, 1);
    run_op(0, 8'hFF, 8'h01, 1);
    run_op(7, 8'hAA, 8'hAA, 1);
    run_op(5, 8'h0F, 8'hF0, 1);
  endtask

  task automatic t_hold;
    run_op(0, 8'hFF, 8'h02, 1);  // C=1, result 01
    run_op(2, 8'h00, 8'h00, 0);  // would clear all, ignored
    run_op(5, 8'h00, 8'h00, 0);
    run_op(1, 8'h10, 8'h10, 0);  // ADC uses held C, result 21
    run_op(1, 8'h10, 8'h10, 1);
  endtask

  initial begin
    t_reset();
    t_add();
    t_adc();
    t_sub();
    t_step();
    t_logic();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule